// File: doc/BRIEF.md
# UART Interrupt Identification and FIFO Control

This block is the register-side logic of a UART that gathers every interrupt cause into one request line and one identification byte. A single bus address is shared by two registers. Reads return the identification byte. Writes program the FIFO control settings: FIFO mode on or off, a receive trigger threshold, and one-shot flush commands for the receive and transmit FIFOs. The serial datapath and the FIFOs themselves live in neighbouring blocks. Those blocks supply fill level, error, timeout, holding-empty and modem-change conditions, and they receive the flush pulses and the trigger selection.

Five causes are ranked in a fixed order: a line error first, then received data, then a character timeout, then an empty transmit holding register, then a modem change. The highest enabled cause sets a 3-bit code and drives the active-low pending bit low. Received data is judged against the programmed threshold, so that request withdraws by itself as soon as software drains the FIFO below it. Reading the identification byte while it reports the holding-empty cause acknowledges that cause until the holding register is written again.

Top module: `uart_int_ident`

## Requirements
- R1: After reset the pending bit is 1, the code is 0, FIFO indication is 00b, the trigger selection is 0, and `irq`, `rx_flush` and `tx_flush` are 0.
- R2: The pending bit is active low. `irq` is high exactly when it is 0. The read byte is {indication[1:0], 2'b00, code[2:0], pending}.
- R3: A write sets FIFO mode to the value of write bit 0. The indication field reads 11b while FIFO mode is on and 00b while it is off.
- R4: In FIFO mode the received-data cause is active while `rx_level` is at or above the threshold chosen by write bits 7:6 (0 gives 1, 1 gives DEPTH/4, 2 gives DEPTH/2, 3 gives DEPTH-2), and it drops once the level falls below the threshold. With FIFO mode off, any nonzero level is enough.
- R5: Write bits 7:6, 2 and 1 are taken only when write bit 0 is 1 and FIFO mode was already on before that write. Otherwise they are ignored.
- R6: While FIFO mode stays on, write bit 1 gives a one-cycle `rx_flush` pulse and write bit 2 gives a one-cycle `tx_flush` pulse, in the cycle after the write. Neither bit is stored.
- R7: A write that turns FIFO mode from on to off pulses both `rx_flush` and `tx_flush` for one cycle.
- R8: Codes in priority order are: line error 3, received data 2, character timeout 6, holding empty 1, modem change 0.
- R9: A cause is considered only while its enable is 1. Data and timeout share `en_rx`. With no enabled cause active, the pending bit is 1 and the code is 0.
- R10: The character-timeout cause is ignored while FIFO mode is off.
- R11: A read strobe taken while the code is 1 and pending is 0 masks the holding-empty cause until a `thr_write` pulse.
- R12: The code and the pending bit reflect the inputs sampled at the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Write strobe for the shared address (FIFO control) |
| ctrl_wdata | input | 8 | Write data: bit0 FIFO mode, bit1 receive flush, bit2 transmit flush, bits 7:6 trigger select |
| id_rd | input | 1 | Read strobe for the shared address (identification) |
| en_line | input | 1 | Line-error cause enable |
| en_rx | input | 1 | Received-data and timeout cause enable |
| en_txe | input | 1 | Holding-empty cause enable |
| en_modem | input | 1 | Modem-change cause enable |
| rx_level | input | LW | Receive FIFO fill count |
| line_err | input | 1 | A line error is recorded |
| char_timeout | input | 1 | Receive character timeout condition |
| thr_empty | input | 1 | Transmit holding register empty |
| thr_write | input | 1 | Holding register written (pulse) |
| modem_chg | input | 1 | A modem status change is recorded |
| irq | output | 1 | Interrupt request |
| pend_n | output | 1 | Pending bit, active low |
| int_id | output | 3 | Encoded cause |
| fifo_ind | output | 2 | FIFO mode indication |
| trig_sel | output | 2 | Current trigger selection |
| id_rdata | output | 8 | Identification byte |
| rx_flush | output | 1 | Receive FIFO flush pulse |
| tx_flush | output | 1 | Transmit FIFO flush pulse |

## Verification
Every threshold is swept across all fill levels from empty to full. A comparison off by one would move the request one entry early or late, and a missing withdraw would leave `irq` stuck once the FIFO drains. All 512 combinations of enables and causes are walked to catch a misranked or ungated cause. The order-of-programming corner is exercised: a control write issued while FIFO mode is still off must leave the trigger unchanged and give no flush, and turning the mode off must flush both FIFOs. The holding-empty acknowledge is checked twice. A read that reports another cause must not mask holding-empty, and a holding-register write must bring the cause back.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

  typedef enum logic [2:0] {
    CODE_MODEM = 3'd0,
    CODE_TXE   = 3'd1,
    CODE_RXD   = 3'd2,
    CODE_LINE  = 3'd3,
    CODE_TMO   = 3'd6
  } cause_code_e;

  typedef struct packed {
    logic line;
    logic rxd;
    logic tmo;
    logic txe;
    logic modem;
  } cause_t;

  // control write field positions, decoded by the register neighbour
  localparam int unsigned WB_MODE = 0;
  localparam int unsigned WB_RXCL = 1;
  localparam int unsigned WB_TXCL = 2;
  localparam int unsigned WB_SELL = 6;

  function automatic int unsigned trig_threshold(input logic [1:0] sel,
                                                 input int unsigned depth);
    case (sel)
      2'd0:    trig_threshold = 1;
      2'd1:    trig_threshold = depth / 4;
      2'd2:    trig_threshold = depth / 2;
      default: trig_threshold = depth - 2;
    endcase
  endfunction

endpackage

// File: rtl/uirq_fifo_ctl.sv
module uirq_fifo_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic       mode_bit,
  input  logic       rxcl_bit,
  input  logic       txcl_bit,
  input  logic [1:0] sel_bits,
  output logic       fifo_on,
  output logic [1:0] trig_sel,
  output logic       rx_flush,
  output logic       tx_flush
);

  logic       on_q, on_d;
  logic [1:0] sel_q, sel_d;
  logic       rxf_q, rxf_d;
  logic       txf_q, txf_d;

  always_comb begin
    on_d  = on_q;
    sel_d = sel_q;
    rxf_d = 1'b0;
    txf_d = 1'b0;
    if (wr) begin
      on_d = mode_bit;
      if (mode_bit && on_q) begin
        sel_d = sel_bits;
        rxf_d = rxcl_bit;
        txf_d = txcl_bit;
      end else if (!mode_bit && on_q) begin
        rxf_d = 1'b1;
        txf_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      sel_q <= 2'd0;
      rxf_q <= 1'b0;
      txf_q <= 1'b0;
    end else begin
      on_q  <= on_d;
      sel_q <= sel_d;
      rxf_q <= rxf_d;
      txf_q <= txf_d;
    end
  end

  assign fifo_on  = on_q;
  assign trig_sel = sel_q;
  assign rx_flush = rxf_q;
  assign tx_flush = txf_q;

endmodule

// File: rtl/uirq_src.sv
module uirq_src
  import uirq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_on,
  input  logic [1:0]    trig_sel,
  input  logic [LW-1:0] rx_level,
  input  logic          en_line,
  input  logic          en_rx,
  input  logic          en_txe,
  input  logic          en_modem,
  input  logic          line_err,
  input  logic          char_timeout,
  input  logic          thr_empty,
  input  logic          thr_write,
  input  logic          modem_chg,
  input  logic          id_rd,
  input  logic [2:0]    cur_code,
  input  logic          cur_pend_n,
  output cause_t        cause
);

  localparam logic [LW-1:0] LVL0 = LW'(trig_threshold(2'd0, DEPTH));
  localparam logic [LW-1:0] LVL1 = LW'(trig_threshold(2'd1, DEPTH));
  localparam logic [LW-1:0] LVL2 = LW'(trig_threshold(2'd2, DEPTH));
  localparam logic [LW-1:0] LVL3 = LW'(trig_threshold(2'd3, DEPTH));

  logic [LW-1:0] thr;
  logic          rx_hit;
  logic          txe_mask_q, txe_mask_d;
  logic          ack_txe;

  always_comb begin
    case (trig_sel)
      2'd0:    thr = LVL0;
      2'd1:    thr = LVL1;
      2'd2:    thr = LVL2;
      default: thr = LVL3;
    endcase
  end

  assign rx_hit  = fifo_on ? (rx_level >= thr) : (rx_level != '0);
  assign ack_txe = id_rd && !cur_pend_n && (cur_code == CODE_TXE);

  always_comb begin
    txe_mask_d = txe_mask_q;
    if (thr_write)    txe_mask_d = 1'b0;
    else if (ack_txe) txe_mask_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txe_mask_q <= 1'b0;
    else        txe_mask_q <= txe_mask_d;
  end

  always_comb begin
    cause.line  = en_line  && line_err;
    cause.rxd   = en_rx    && rx_hit;
    cause.tmo   = en_rx    && fifo_on && char_timeout;
    cause.txe   = en_txe   && thr_empty && !txe_mask_q;
    cause.modem = en_modem && modem_chg;
  end

endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
  import uirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cause_t     cause,
  output logic [2:0] code,
  output logic       pend_n
);

  logic [2:0] code_d, code_q;
  logic       pend_n_d, pend_n_q;

  always_comb begin
    pend_n_d = 1'b0;
    if (cause.line)       code_d = CODE_LINE;
    else if (cause.rxd)   code_d = CODE_RXD;
    else if (cause.tmo)   code_d = CODE_TMO;
    else if (cause.txe)   code_d = CODE_TXE;
    else if (cause.modem) code_d = CODE_MODEM;
    else begin
      code_d   = 3'd0;
      pend_n_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= 3'd0;
      pend_n_q <= 1'b1;
    end else begin
      code_q   <= code_d;
      pend_n_q <= pend_n_d;
    end
  end

  assign code   = code_q;
  assign pend_n = pend_n_q;

endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
  import uirq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic [7:0]    ctrl_wdata,
  input  logic          id_rd,
  input  logic          en_line,
  input  logic          en_rx,
  input  logic          en_txe,
  input  logic          en_modem,
  input  logic [LW-1:0] rx_level,
  input  logic          line_err,
  input  logic          char_timeout,
  input  logic          thr_empty,
  input  logic          thr_write,
  input  logic          modem_chg,
  output logic          irq,
  output logic          pend_n,
  output logic [2:0]    int_id,
  output logic [1:0]    fifo_ind,
  output logic [1:0]    trig_sel,
  output logic [7:0]    id_rdata,
  output logic          rx_flush,
  output logic          tx_flush
);

  logic   fifo_on;
  cause_t cause;
  logic   unused_wbits;

  assign unused_wbits = ^ctrl_wdata[5:3];

  uirq_fifo_ctl u_fctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (ctrl_wr),
    .mode_bit (ctrl_wdata[WB_MODE]),
    .rxcl_bit (ctrl_wdata[WB_RXCL]),
    .txcl_bit (ctrl_wdata[WB_TXCL]),
    .sel_bits (ctrl_wdata[WB_SELL +: 2]),
    .fifo_on  (fifo_on),
    .trig_sel (trig_sel),
    .rx_flush (rx_flush),
    .tx_flush (tx_flush)
  );

  uirq_src #(.DEPTH(DEPTH), .LW(LW)) u_src (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_on      (fifo_on),
    .trig_sel     (trig_sel),
    .rx_level     (rx_level),
    .en_line      (en_line),
    .en_rx        (en_rx),
    .en_txe       (en_txe),
    .en_modem     (en_modem),
    .line_err     (line_err),
    .char_timeout (char_timeout),
    .thr_empty    (thr_empty),
    .thr_write    (thr_write),
    .modem_chg    (modem_chg),
    .id_rd        (id_rd),
    .cur_code     (int_id),
    .cur_pend_n   (pend_n),
    .cause        (cause)
  );

  uirq_prio u_prio (
    .clk    (clk),
    .rst_n  (rst_n),
    .cause  (cause),
    .code   (int_id),
    .pend_n (pend_n)
  );

  assign irq      = !pend_n;
  assign fifo_ind = {2{fifo_on}};
  assign id_rdata = {fifo_ind, 2'b00, int_id, pend_n};

endmodule

// File: rtl/uirq_chk.sv
module uirq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctrl_wr,
  input logic [7:0] ctrl_wdata,
  input logic       en_line,
  input logic       en_rx,
  input logic       en_txe,
  input logic       en_modem,
  input logic       line_err,
  input logic       pend_n,
  input logic [2:0] int_id,
  input logic [1:0] fifo_ind,
  input logic [1:0] trig_sel,
  input logic       rx_flush,
  input logic       tx_flush
);

  // R8
  line_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_line && line_err) |=> (int_id == 3'd3 && !pend_n));

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_line && !en_rx && !en_txe && !en_modem) |=> (pend_n && int_id == 3'd0));

  // R6
  rx_flush_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> !rx_flush);

  // R6
  tx_flush_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> !tx_flush);

  // R3
  ind_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ind[0] == fifo_ind[1]);

  // R5
  sel_hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && fifo_ind == 2'b00) |=> ($stable(trig_sel) && !rx_flush && !tx_flush));

  // R7
  off_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !ctrl_wdata[0] && fifo_ind == 2'b11) |=> (rx_flush && tx_flush));

endmodule

bind uart_int_ident uirq_chk u_uirq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_wr    (ctrl_wr),
  .ctrl_wdata (ctrl_wdata),
  .en_line    (en_line),
  .en_rx      (en_rx),
  .en_txe     (en_txe),
  .en_modem   (en_modem),
  .line_err   (line_err),
  .pend_n     (pend_n),
  .int_id     (int_id),
  .fifo_ind   (fifo_ind),
  .trig_sel   (trig_sel),
  .rx_flush   (rx_flush),
  .tx_flush   (tx_flush)
);

// File: tb/uart_int_ident_bench.sv
`timescale 1ns/1ps
module uart_int_ident_bench;

  localparam int unsigned DEPTH = 16;
  localparam int unsigned LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctrl_wr = 1'b0;
  logic [7:0]    ctrl_wdata = 8'd0;
  logic          id_rd = 1'b0;
  logic          en_line = 1'b0, en_rx = 1'b0, en_txe = 1'b0, en_modem = 1'b0;
  logic [LW-1:0] rx_level = '0;
  logic          line_err = 1'b0, char_timeout = 1'b0, thr_empty = 1'b0;
  logic          thr_write = 1'b0, modem_chg = 1'b0;
  logic          irq, pend_n, rx_flush, tx_flush;
  logic [2:0]    int_id;
  logic [1:0]    fifo_ind, trig_sel;
  logic [7:0]    id_rdata;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  uart_int_ident #(.DEPTH(DEPTH)) u_uart_int_ident (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .id_rd(id_rd), .en_line(en_line), .en_rx(en_rx), .en_txe(en_txe),
    .en_modem(en_modem), .rx_level(rx_level), .line_err(line_err),
    .char_timeout(char_timeout), .thr_empty(thr_empty), .thr_write(thr_write),
    .modem_chg(modem_chg), .irq(irq), .pend_n(pend_n), .int_id(int_id),
    .fifo_ind(fifo_ind), .trig_sel(trig_sel), .id_rdata(id_rdata),
    .rx_flush(rx_flush), .tx_flush(tx_flush)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] v);
    ctrl_wr = 1'b1;
    ctrl_wdata = v;
    step();
    ctrl_wr = 1'b0;
  endtask

  function automatic int thr_of(input int s);
    if (s == 0) return 1;
    if (s == 1) return DEPTH / 4;
    if (s == 2) return DEPTH / 2;
    return DEPTH - 2;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #12;
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 pend_n", pend_n, 1);
    chk("R1 int_id", int_id, 0);
    chk("R1 fifo_ind", fifo_ind, 0);
    chk("R1 trig_sel", trig_sel, 0);
    chk("R1 irq", irq, 0);
    chk("R1 flushes", {rx_flush, tx_flush}, 0);

    // R4 non-FIFO: any nonzero level; R10 timeout ignored
    en_rx = 1'b1;
    for (int l = 0; l <= DEPTH; l++) begin
      rx_level = LW'(l);
      step();
      chk("R4 nofifo code", int_id, (l != 0) ? 2 : 0);
      chk("R4 nofifo pend", pend_n, (l != 0) ? 0 : 1);
    end
    rx_level = '0;
    char_timeout = 1'b1;
    step();
    chk("R10 timeout ignored off", pend_n, 1);
    char_timeout = 1'b0;

    // R3 enable FIFO mode
    wr(8'h01);
    chk("R3 ind on", fifo_ind, 3);
    chk("R5 sel untouched on first write", trig_sel, 0);

    // R4 threshold sweeps
    for (int s = 0; s < 4; s++) begin
      wr({s[1:0], 6'b000001});
      chk("R4 trig_sel", trig_sel, s);
      for (int l = 0; l <= DEPTH; l++) begin
        rx_level = LW'(l);
        step();
        chk("R4 fifo code", int_id, (l >= thr_of(s)) ? 2 : 0);
        chk("R2 irq", irq, (l >= thr_of(s)) ? 1 : 0);
      end
      // drain below the threshold: request withdraws
      rx_level = LW'(thr_of(s) - 1);
      step();
      chk("R4 withdraw", pend_n, 1);
    end
    rx_level = '0;

    // R7 turning off flushes both
    wr(8'h01);
    chk("R5 sel back to 0", trig_sel, 0);
    wr(8'h00);
    chk("R7 both flush", {rx_flush, tx_flush}, 3);
    chk("R3 ind off", fifo_ind, 0);
    step();
    chk("R6 flush single cycle", {rx_flush, tx_flush}, 0);

    // R5 programming while off is ignored
    wr(8'hC7);
    chk("R5 sel ignored", trig_sel, 0);
    chk("R5 no flush", {rx_flush, tx_flush}, 0);
    chk("R3 ind on again", fifo_ind, 3);

    // R6 individual flush pulses
    wr(8'h03);
    chk("R6 rx flush", {rx_flush, tx_flush}, 2);
    step();
    chk("R6 rx flush gone", rx_flush, 0);
    wr(8'h05);
    chk("R6 tx flush", {rx_flush, tx_flush}, 1);
    step();
    chk("R6 tx flush gone", tx_flush, 0);

    // R8 R9 R2 exhaustive cause sweep, FIFO on, trigger 1
    for (int c = 0; c < 512; c++) begin
      logic [8:0] b;
      int eid;
      int ep;
      b = 9'(c);
      en_line = b[0]; en_rx = b[1]; en_txe = b[2]; en_modem = b[3];
      line_err = b[4]; rx_level = b[5] ? LW'(DEPTH) : '0;
      char_timeout = b[6]; thr_empty = b[7]; modem_chg = b[8];
      step();
      ep = 0;
      if (b[0] && b[4])      eid = 3;
      else if (b[1] && b[5]) eid = 2;
      else if (b[1] && b[6]) eid = 6;
      else if (b[2] && b[7]) eid = 1;
      else if (b[3] && b[8]) eid = 0;
      else begin eid = 0; ep = 1; end
      chk("R8 code", int_id, eid);
      chk("R9 pend", pend_n, ep);
      chk("R2 byte", id_rdata, {2'b11, 2'b00, 3'(eid), 1'(ep)});
    end

    // R12 one cycle latency
    en_line = 1'b0; en_rx = 1'b0; en_txe = 1'b0; en_modem = 1'b0;
    line_err = 1'b0; rx_level = '0; char_timeout = 1'b0;
    thr_empty = 1'b0; modem_chg = 1'b0;
    step();
    en_line = 1'b1; line_err = 1'b1;
    #1;
    chk("R12 not yet", pend_n, 1);
    step();
    chk("R12 after edge", int_id, 3);
    en_line = 1'b0; line_err = 1'b0;

    // R11 holding-empty acknowledge
    en_txe = 1'b1; thr_empty = 1'b1;
    step();
    chk("R11 txe shown", int_id, 1);
    id_rd = 1'b1; step(); id_rd = 1'b0;
    step();
    chk("R11 masked", pend_n, 1);
    thr_write = 1'b1; step(); thr_write = 1'b0;
    step();
    chk("R11 restored", int_id, 1);
    chk("R11 restored pend", pend_n, 0);
    // a read reporting received data does not mask holding-empty
    en_rx = 1'b1; rx_level = LW'(DEPTH);
    step();
    chk("R11 rx over txe", int_id, 2);
    id_rd = 1'b1; step(); id_rd = 1'b0;
    rx_level = '0;
    step();
    chk("R11 txe kept", int_id, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule